// File: doc/BRIEF.md
# Scaled Fixed-Point Pack Unit with Saturation

This block narrows wide fixed-point pixel lanes into small saturated lanes. Each conversion shifts every source lane left by a programmable scale, moves it right by a fixed amount that depends on the mode, and clamps it into the output range. The scale comes from a 64-bit graphics status register that the block holds. Software writes that register whole through a write-enable port.

Three packing modes are selected per operation:
- Four signed 16-bit lanes become four unsigned bytes.
- Two signed 32-bit lanes become unsigned bytes, which are merged into a byte-shifted copy of the first operand. This lets repeated calls build up a packed word step by step.
- Two signed 32-bit lanes become two signed halfwords.

An operation starts with a one-cycle `start` strobe. Its registered result appears together with a one-cycle `done` pulse on the next cycle.

Top module: `pixel_pack`

## Requirements
- R1: The status register resets to zero and loads all 64 bits of `stat_wdata` on a clock edge where `stat_we` is high. An operation started in the same cycle as a write uses the old value. An operation started in a later cycle uses the new value.
- R2: `done` is high exactly in the cycle after each `start`, and is low otherwise. `result` changes only on the edge that raises `done`. After reset, `result` and `done` are zero.
- R3: In mode 2'b00, the scale is status bits [6:3]. For each i from 0 to 3, the signed 16-bit lane `src_b[16i+15:16i]` is shifted left by the scale, then arithmetically right by 7, and clamped to 0..255. The result goes into `result[8i+7:8i]`, and `result[63:32]` is zero.
- R4: In mode 2'b00, status bit 7 has no effect on the result.
- R5: In mode 2'b01, the scale is status bits [7:3]. Each signed 32-bit lane w of `src_b` is shifted left by the scale, then arithmetically right by 23, and clamped to 0..255.
- R6: In mode 2'b01, the result is `src_a` shifted left by 8 bits, with bits [7:0] and [39:32] cleared. The clamped byte of lane w is then placed in `result[32w+7:32w]`.
- R7: In mode 2'b10, the scale is status bits [7:3]. Each signed 32-bit lane w of `src_b` is shifted left by the scale, then arithmetically right by 16, and clamped to -32768..32767. The low 16 bits of the clamped value go into `result[16w+15:16w]`, and `result[63:32]` is zero.
- R8: A left shift by any scale up to 31 never wraps. The largest positive lanes saturate to the upper limit, and the most negative lanes saturate to the lower limit.
- R9: Mode 2'b11 produces an all-zero result with the normal `done` pulse.
- R10: In modes 2'b00 and 2'b10, `src_a` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_we | input | 1 | Write enable for the status register |
| stat_wdata | input | 64 | New status register value |
| start | input | 1 | Begin one pack operation this cycle |
| mode | input | 2 | Pack mode: 00 16→u8, 01 32→u8 merge, 10 32→s16, 11 zero |
| src_a | input | 64 | Merge operand (used by mode 01 only) |
| src_b | input | 64 | Lanes to be packed |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 64 | Packed result, held until the next operation |

## Verification
Each mode is driven with lanes placed just below, at, and above both clamp limits, so that a wrong right-shift amount or a wrong clamp bound changes the output byte. The scale is swept from zero to its field maximum. With the largest scale and full-scale positive and negative lanes, an intermediate that is too narrow shows up as a wrap instead of saturation. Status bit 7 is toggled under mode 00, and `src_a` is varied under modes 00 and 10, to show that both have no effect. A status write issued in the same cycle as `start` tells apart the old and new scale timing. A stream of pseudo-random operands, issued back to back, covers the merge placement and the lane order.

// File: rtl/pixel_pack_pkg.sv
package pixel_pack_pkg;

    localparam int DATA_W    = 64;
    localparam int SCALE_W   = 5;
    localparam int SCALE_LSB = 3;

    typedef enum logic [1:0] {
        PK_U8_FROM16  = 2'b00,
        PK_U8_MERGE32 = 2'b01,
        PK_S16_FROM32 = 2'b10,
        PK_ZERO       = 2'b11
    } pk_mode_e;

    typedef struct packed {
        logic [SCALE_W-1:0] wide;    // five-bit scale field
        logic [SCALE_W-1:0] narrow;  // four-bit field, zero extended
    } pk_scale_t;

    function automatic pk_scale_t pk_scales(input logic [DATA_W-1:0] stat);
        pk_scale_t s;
        s.wide   = stat[SCALE_LSB +: SCALE_W];
        s.narrow = {1'b0, stat[SCALE_LSB +: SCALE_W-1]};
        return s;
    endfunction

    // Upper source bytes moved up one byte; the slots for packed bytes cleared.
    function automatic logic [DATA_W-1:0] pk_merge_base(input logic [DATA_W-1:0] a);
        return {a[55:32], 8'h00, a[23:0], 8'h00};
    endfunction

endpackage

// File: rtl/pp_status_reg.sv
module pp_status_reg
    import pixel_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    // R1
    stat_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(wdata));

    // R1
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/pp_sat_lane.sv
module pp_sat_lane #(
    parameter int IN_W       = 16,
    parameter int SHR        = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]  din,
    input  logic [4:0]       scale,
    output logic [OUT_W-1:0] dout
);

    localparam int WIDE_W = 64;
    localparam logic signed [WIDE_W-1:0] ONE = 64'sd1;
    localparam logic signed [WIDE_W-1:0] HI_LIM =
        SIGNED_OUT ? (ONE <<< (OUT_W - 1)) - ONE : (ONE <<< OUT_W) - ONE;
    localparam logic signed [WIDE_W-1:0] LO_LIM =
        SIGNED_OUT ? -(ONE <<< (OUT_W - 1)) : 64'sd0;

    logic signed [WIDE_W-1:0] ext_v;
    logic signed [WIDE_W-1:0] shl_v;
    logic signed [WIDE_W-1:0] fix_v;

    always_comb begin
        ext_v = {{(WIDE_W-IN_W){din[IN_W-1]}}, din};
        shl_v = ext_v <<< scale;
        fix_v = shl_v >>> SHR;
        if (fix_v > HI_LIM)
            dout = HI_LIM[OUT_W-1:0];
        else if (fix_v < LO_LIM)
            dout = LO_LIM[OUT_W-1:0];
        else
            dout = fix_v[OUT_W-1:0];
    end

endmodule

// File: rtl/pixel_pack.sv
module pixel_pack
    import pixel_pack_pkg::*;
#(
    parameter int N16 = 4,
    parameter int N32 = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stat_we,
    input  logic [63:0] stat_wdata,
    input  logic        start,
    input  logic [1:0]  mode,
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    output logic        done,
    output logic [63:0] result
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] stat_q;
    pk_scale_t         scl;
    pk_mode_e          mode_e;
    logic [DATA_W-1:0] nxt;
    logic [7:0]        u8_n [N16];
    logic [7:0]        u8_w [N32];
    logic [15:0]       s16_w [N32];
    logic              stat_unused_bits;
    logic              srca_unused_bits;

    pp_status_reg u_stat (
        .clk   (clk),
        .rst   (rst),
        .we    (stat_we),
        .wdata (stat_wdata),
        .q     (stat_q)
    );

    assign scl              = pk_scales(stat_q);
    assign mode_e           = pk_mode_e'(mode);
    assign stat_unused_bits = ^{stat_q[63:8], stat_q[2:0]};
    assign srca_unused_bits = ^{src_a[63:56], src_a[31:24]};

    for (genvar i = 0; i < N16; i++) begin : g_narrow
        pp_sat_lane #(.IN_W(16), .SHR(7), .OUT_W(8), .SIGNED_OUT(1'b0)) u_lane (
            .din   (src_b[16*i +: 16]),
            .scale (scl.narrow),
            .dout  (u8_n[i])
        );
    end

    for (genvar w = 0; w < N32; w++) begin : g_wide
        pp_sat_lane #(.IN_W(32), .SHR(23), .OUT_W(8), .SIGNED_OUT(1'b0)) u_byte (
            .din   (src_b[32*w +: 32]),
            .scale (scl.wide),
            .dout  (u8_w[w])
        );
        pp_sat_lane #(.IN_W(32), .SHR(16), .OUT_W(16), .SIGNED_OUT(1'b1)) u_half (
            .din   (src_b[32*w +: 32]),
            .scale (scl.wide),
            .dout  (s16_w[w])
        );
    end

    always_comb begin
        nxt = '0;
        unique case (mode_e)
            PK_U8_FROM16: begin
                for (int i = 0; i < N16; i++)
                    nxt[8*i +: 8] = u8_n[i];
            end
            PK_U8_MERGE32: begin
                nxt = pk_merge_base(src_a);
                for (int w = 0; w < N32; w++)
                    nxt[HALF_W*w +: 8] = u8_w[w];
            end
            PK_S16_FROM32: begin
                for (int w = 0; w < N32; w++)
                    nxt[16*w +: 16] = s16_w[w];
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= start;
            if (start)
                result <= nxt;
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'b00) |=> result[63:32] == 32'h0);

    // R7
    fixed_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'b10) |=> result[63:32] == 32'h0);

    // R6
    merge_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'b01) |=> (result[31:8] == $past(src_a[23:0]) &&
                                      result[63:40] == $past(src_a[55:32])));

    // R9
    zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'b11) |=> result == 64'h0);

endmodule

// File: tb/pixel_pack_tb.sv
`timescale 1ns/1ps
module pixel_pack_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stat_we = 1'b0;
    logic [63:0] stat_wdata = '0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        done;
    logic [63:0] result;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [63:0] gsr_m = '0;
    logic [63:0] last_exp = '0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    pixel_pack u_dut (
        .clk(clk), .rst(rst), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .start(start), .mode(mode), .src_a(src_a), .src_b(src_b),
        .done(done), .result(result)
    );

    function automatic longint clampl(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [1:0] m, logic [63:0] g,
                                          logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        int s4 = int'(g[6:3]);
        int s5 = int'(g[7:3]);
        longint v;
        case (m)
            2'b00: for (int i = 0; i < 4; i++) begin
                v = longint'($signed(b[16*i +: 16]));
                v = (v <<< s4) >>> 7;
                v = clampl(v, 0, 255);
                r[8*i +: 8] = v[7:0];
            end
            2'b01: begin
                r = (a << 8) & ~64'h000000ff000000ff;
                for (int w = 0; w < 2; w++) begin
                    v = longint'($signed(b[32*w +: 32]));
                    v = (v <<< s5) >>> 23;
                    v = clampl(v, 0, 255);
                    r[32*w +: 8] = r[32*w +: 8] | v[7:0];
                end
            end
            2'b10: for (int w = 0; w < 2; w++) begin
                v = longint'($signed(b[32*w +: 32]));
                v = (v <<< s5) >>> 16;
                v = clampl(v, -32768, 32767);
                r[16*w +: 16] = v[15:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one start per call, expected value pushed to the scoreboard
    task automatic issue(string tag, logic [1:0] m, logic [63:0] a, logic [63:0] b);
        start = 1'b1; mode = m; src_a = a; src_b = b;
        exp_q.push_back(model(m, gsr_m, a, b));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    // start together with a status write: the old scale applies (R1)
    task automatic issue_wr(string tag, logic [1:0] m, logic [63:0] a,
                            logic [63:0] b, logic [63:0] g);
        stat_we = 1'b1; stat_wdata = g;
        start = 1'b1; mode = m; src_a = a; src_b = b;
        exp_q.push_back(model(m, gsr_m, a, b));
        tag_q.push_back(tag);
        gsr_m = g;
        @(negedge clk);
        start = 1'b0; stat_we = 1'b0;
    endtask

    task automatic wr_stat(logic [63:0] g);
        stat_we = 1'b1; stat_wdata = g;
        @(negedge clk);
        stat_we = 1'b0;
        gsr_m = g;
    endtask

    // monitor: pops and compares on every done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2: done with no pending op, actual 1 expected 0");
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), result, last_exp);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset result", result, 64'h0);
        check("R2 reset done", {63'h0, done}, 64'h0);

        // R1: reset status gives scale 0
        issue("R1 reset scale zero", 2'b00, 64'h0, 64'h3FFF_FF00_0100_7F80);
        @(negedge clk);
        // R3: clamp edges at scale 0
        issue("R3 scale0 edges", 2'b00, 64'h0, 64'h0080_807F_0000_7FFF);
        wr_stat(64'h78);
        issue("R3 scale15", 2'b00, 64'h0, 64'h0002_FFFF_0000_0001);
        wr_stat(64'h10);
        issue("R3 scale2", 2'b00, 64'h0, 64'h1234_0FFF_0040_8001);
        wr_stat(64'h90);
        issue("R4 bit7 ignored", 2'b00, 64'h0, 64'h1234_0FFF_0040_8001);
        check("R4 bit7 model", model(2'b00, 64'h90, 0, 64'h1234_0FFF_0040_8001),
              model(2'b00, 64'h10, 0, 64'h1234_0FFF_0040_8001));
        // R10: src_a ignored in modes 00 and 10
        issue("R10 srca mode00", 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_0FFF_0040_8001);
        issue("R10 srca mode10 a", 2'b10, 64'h0, 64'h0123_4567_FFFF_8000);
        issue("R10 srca mode10 b", 2'b10, 64'hA5A5_5A5A_DEAD_BEEF, 64'h0123_4567_FFFF_8000);
        // R5 / R6: merge
        wr_stat(64'h0);
        issue("R6 merge scale0", 2'b01, 64'h1122_3344_5566_7788, 64'h7F80_0000_0080_0000);
        wr_stat(64'h40);
        issue("R5 scale8", 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_7FFF_FFFF_0100);
        // R8: full scale, extreme lanes
        wr_stat(64'hF8);
        issue("R8 merge max", 2'b01, 64'h0, 64'h8000_0000_7FFF_FFFF);
        issue("R8 fixed max", 2'b10, 64'h0, 64'h8000_0000_7FFF_FFFF);
        issue("R8 narrow max", 2'b00, 64'h0, 64'h8000_7FFF_FFFF_0001);
        // R7: fixed mode clamps
        wr_stat(64'h0);
        issue("R7 scale0", 2'b10, 64'h0, 64'h8000_0000_7FFF_FFFF);
        wr_stat(64'h80);
        issue("R7 scale16", 2'b10, 64'h0, 64'hFFFF_8000_0000_7FFF);
        // R9
        issue("R9 zero mode", 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        // R1: write in the same cycle as start, then next op sees new value
        wr_stat(64'h0);
        issue_wr("R1 same cycle old", 2'b00, 64'h0, 64'h0001_0010_0100_0200, 64'h38);
        issue("R1 next cycle new", 2'b00, 64'h0, 64'h0001_0010_0100_0200);
        // R2: idle, result holds
        repeat (3) @(negedge clk);
        check("R2 hold", result, last_exp);
        check("R2 idle done", {63'h0, done}, 64'h0);
        // pseudo-random back-to-back stream across modes and scales
        for (int k = 0; k < 40; k++) begin
            logic [63:0] aa, bb;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            aa = x;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            bb = x;
            if (k % 5 == 0) wr_stat({56'h0, x[7:0]});
            issue("R3 R5 R6 R7 stream", x[9:8], aa, bb);
        end
        repeat (3) @(negedge clk);
        check("R2 queue drained", 64'(exp_q.size()), 64'h0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule